// File: doc/BRIEF.md
# Compact 16-bit Register CPU Core

This block is a small multicycle processor for control tasks. It has four 16-bit general registers (register 0 is called A), an instruction pointer and a stack pointer. It fetches 16-bit instruction words from a word-addressed synchronous RAM and steps through fetch, decode and execute. Arithmetic and logic operations are done in a separate ALU. Branch conditions are evaluated in a separate compare unit.

Data and program share one RAM port. The stack has its own synchronous RAM port. A host service request pauses the core. The core raises a one-cycle strobe that carries register A, then waits for an acknowledge. A halt instruction stops the core for good, until the next reset.

Every instruction word uses the same layout. The opcode is in bits [3:0], the destination register D in [5:4] and the source register S in [7:6]. The opcodes are:

| Code | Instruction |
|---|---|
| 0 | register move |
| 1 | immediate |
| 2 | register-based load |
| 3 | direct store |
| 4 | arithmetic |
| 5 | call |
| 6 | compare-and-jump |
| 7 | push |
| 8 | pop |
| 9 | relative jump |
| 10 | register jump |
| 11 | direct load |
| 12 | register-based store |
| 13 | no-argument group |

Top module: `nib16_core`

## Requirements
- R1: While rst is high the core makes no memory or stack write, sys_req and halted are low. After rst falls, the first fetch reads word address 0. All four registers and the stack pointer read as zero.
- R2: Opcode 0 writes S + sign-extended [15:8] into D.
- R3: Opcode 1 uses an 8-bit value in [15:8] and a mode in [7:6]. Mode 0 sets D to the zero-extended value. Mode 1 sets D to value<<8. Mode 2 adds the sign-extended value to D. Mode 3 adds value<<8 to D.
- R4: Opcode 4 applies operation [11:8] to D (first operand) and S. The operations are: 0 add, 1 D-S, 2 low half of the product, 3 D/S (giving 0xFFFF when S is 0), 4 D+1, 5 D-1, 6 D<<[15:13], 7 D>>[15:13] (logical), 8 and, 9 or, 10 xor, 11 not D. Bit [12]=0 writes the result to D. Bit [12]=1 writes it to S.
- R5: Loads and stores work as follows.
  - Opcode 11 loads D from the absolute word address in [15:6].
  - Opcode 3 stores D to that address.
  - Opcode 2 loads D from S + sign-extended [15:8].
  - Opcode 12 stores S at the address held in D.
- R6: The stack pointer grows upwards.
  - Opcode 7 writes S at the stack pointer, then increments the pointer.
  - Opcode 8 decrements the pointer, then loads D from the new position.
- R7: Opcode 5 pushes the address of the next instruction and jumps to D. Opcode 13 with sub-code [7:4]=2 pops the stack into the instruction pointer.
- R8: Opcode 9 adds the signed 12-bit value in [15:4] to the address of the next instruction. Opcode 10 jumps to S.
- R9: Opcode 6 jumps to the register selected by [9:8] when condition [12:10] holds on D and S. The conditions are: 0 equal, 1 not equal, 2 less, 3 greater, 4 less-or-equal, 5 greater-or-equal (all unsigned), 6 D zero, 7 D non-zero. Otherwise execution falls through.
- R10: Opcode 13 with sub-code 0 drives sys_req for exactly one cycle, with sys_arg equal to A. The core makes no further fetch or write until sys_ack, then resumes at the next instruction.
- R11: Opcode 13 with sub-code 1 raises halted. Halted then stays high, the memory address is held and no writes occur.
- R12: Opcodes 14 and 15, and sub-codes 3 to 15 of opcode 13, change no register and no memory.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| mem_addr | output | MEM_AW | Word address for fetches, loads and stores |
| mem_wdata | output | 16 | Store data |
| mem_we | output | 1 | Store strobe |
| mem_rdata | input | 16 | Read data, valid one cycle after the address |
| stk_addr | output | STK_AW | Stack RAM word address |
| stk_wdata | output | 16 | Stack write data |
| stk_we | output | 1 | Stack write strobe |
| stk_rdata | input | 16 | Stack read data, valid one cycle after the address |
| sys_req | output | 1 | One-cycle host service request |
| sys_arg | output | 16 | Register A, valid with sys_req |
| sys_ack | input | 1 | Host completion, resumes the core |
| halted | output | 1 | High once a halt instruction has executed |

## Verification
The hardest state to reach from the ports is the paused service request. The core must sit frozen for many cycles with sys_req already gone, and it must not drift to a new fetch address before the acknowledge. The bench acknowledges only after a long delay. It records every address the core presents while it waits, and flags any change. A second hard case is the return through a stack slot that an earlier push and pop already used. The call-and-return program first pushes and pops two values, so the call overwrites a slot that held stale data. The bench then reads that slot back from its stack model.

// File: rtl/nib16_pkg.sv
package nib16_pkg;

    localparam int WORD_W = 16;
    localparam int RIDX_W = 2;

    // Opcode field [3:0]
    localparam logic [3:0] OP_MOVR = 4'd0;
    localparam logic [3:0] OP_IMM  = 4'd1;
    localparam logic [3:0] OP_LDRB = 4'd2;
    localparam logic [3:0] OP_STAB = 4'd3;
    localparam logic [3:0] OP_ALU  = 4'd4;
    localparam logic [3:0] OP_CALL = 4'd5;
    localparam logic [3:0] OP_BCMP = 4'd6;
    localparam logic [3:0] OP_PUSH = 4'd7;
    localparam logic [3:0] OP_POP  = 4'd8;
    localparam logic [3:0] OP_JREL = 4'd9;
    localparam logic [3:0] OP_JREG = 4'd10;
    localparam logic [3:0] OP_LDAB = 4'd11;
    localparam logic [3:0] OP_STRB = 4'd12;
    localparam logic [3:0] OP_MISC = 4'd13;

    // Sub-codes of the no-argument group, field [7:4]
    localparam logic [3:0] SUB_SVC = 4'd0;
    localparam logic [3:0] SUB_STOP = 4'd1;
    localparam logic [3:0] SUB_RETN = 4'd2;

    // ALU operation codes
    localparam logic [3:0] AOP_ADD = 4'd0;
    localparam logic [3:0] AOP_SUB = 4'd1;
    localparam logic [3:0] AOP_MUL = 4'd2;
    localparam logic [3:0] AOP_DIV = 4'd3;
    localparam logic [3:0] AOP_INC = 4'd4;
    localparam logic [3:0] AOP_DEC = 4'd5;
    localparam logic [3:0] AOP_SHL = 4'd6;
    localparam logic [3:0] AOP_SHR = 4'd7;
    localparam logic [3:0] AOP_AND = 4'd8;
    localparam logic [3:0] AOP_OR  = 4'd9;
    localparam logic [3:0] AOP_XOR = 4'd10;
    localparam logic [3:0] AOP_NOT = 4'd11;

    typedef enum logic [2:0] {
        S_FETCH,
        S_DECODE,
        S_EXEC,
        S_LOAD,
        S_SVCREQ,
        S_SVCWAIT,
        S_HALT
    } state_e;

    typedef enum logic [1:0] {
        LD_MEM,
        LD_STK,
        LD_IP
    } ldsel_e;

    typedef struct packed {
        state_e              st;
        logic [WORD_W-1:0]   ip;
        logic [WORD_W-1:0]   sp;
        logic [WORD_W-1:0]   ir;
        ldsel_e              sel;
        logic [RIDX_W-1:0]   dst;
    } core_t;

endpackage

// File: rtl/nib16_alu.sv
module nib16_alu
    import nib16_pkg::*;
(
    input  logic [3:0]        op,
    input  logic [2:0]        shamt,
    input  logic [WORD_W-1:0] x,
    input  logic [WORD_W-1:0] y,
    output logic [WORD_W-1:0] res
);

    logic [2*WORD_W-1:0] prod;

    always_comb begin
        prod = x * y;
        case (op)
            AOP_ADD: res = x + y;
            AOP_SUB: res = x - y;
            AOP_MUL: res = prod[WORD_W-1:0];
            AOP_DIV: res = (y == '0) ? '1 : x / y;
            AOP_INC: res = x + 1'b1;
            AOP_DEC: res = x - 1'b1;
            AOP_SHL: res = x << shamt;
            AOP_SHR: res = x >> shamt;
            AOP_AND: res = x & y;
            AOP_OR:  res = x | y;
            AOP_XOR: res = x ^ y;
            AOP_NOT: res = ~x;
            default: res = x;
        endcase
    end

    // The upper half of the product is dropped.
    logic unused_hi;
    assign unused_hi = ^prod[2*WORD_W-1:WORD_W];

endmodule

// File: rtl/nib16_cmp.sv
module nib16_cmp
    import nib16_pkg::*;
(
    input  logic [2:0]        cond,
    input  logic [WORD_W-1:0] x,
    input  logic [WORD_W-1:0] y,
    output logic              take
);

    always_comb begin
        case (cond)
            3'd0: take = (x == y);
            3'd1: take = (x != y);
            3'd2: take = (x <  y);
            3'd3: take = (x >  y);
            3'd4: take = (x <= y);
            3'd5: take = (x >= y);
            3'd6: take = (x == '0);
            default: take = (x != '0);
        endcase
    end

endmodule

// File: rtl/nib16_regs.sv
module nib16_regs
    import nib16_pkg::*;
#(
    parameter int IW = RIDX_W
)(
    input  logic              clk,
    input  logic              rst,
    input  logic [IW-1:0]     ra_d,
    input  logic [IW-1:0]     ra_s,
    input  logic [IW-1:0]     ra_t,
    output logic [WORD_W-1:0] rd_d,
    output logic [WORD_W-1:0] rd_s,
    output logic [WORD_W-1:0] rd_t,
    output logic [WORD_W-1:0] rd_a,
    input  logic              we,
    input  logic [IW-1:0]     wa,
    input  logic [WORD_W-1:0] wd
);

    localparam int NREG = 1 << IW;

    logic [WORD_W-1:0] regs_q [NREG];
    logic [WORD_W-1:0] regs_d [NREG];

    always_comb begin
        for (int i = 0; i < NREG; i++) begin
            regs_d[i] = (we && (wa == IW'(i))) ? wd : regs_q[i];
        end
    end

    for (genvar g = 0; g < NREG; g++) begin : g_reg
        always_ff @(posedge clk) begin
            if (rst) regs_q[g] <= '0;
            else     regs_q[g] <= regs_d[g];
        end
    end

    assign rd_d = regs_q[ra_d];
    assign rd_s = regs_q[ra_s];
    assign rd_t = regs_q[ra_t];
    assign rd_a = regs_q[0];

endmodule

// File: rtl/nib16_core.sv
module nib16_core
    import nib16_pkg::*;
#(
    parameter int MEM_AW = 10,
    parameter int STK_AW = 8
)(
    input  logic              clk,
    input  logic              rst,
    output logic [MEM_AW-1:0] mem_addr,
    output logic [15:0]       mem_wdata,
    output logic              mem_we,
    input  logic [15:0]       mem_rdata,
    output logic [STK_AW-1:0] stk_addr,
    output logic [15:0]       stk_wdata,
    output logic              stk_we,
    input  logic [15:0]       stk_rdata,
    output logic              sys_req,
    output logic [15:0]       sys_arg,
    input  logic              sys_ack,
    output logic              halted
);

    core_t cur_q, nxt_d;

    logic [RIDX_W-1:0] f_d, f_s, f_t;
    logic [3:0]        f_op;
    logic [WORD_W-1:0] imm_s, imm_h, rel12;
    logic [WORD_W-1:0] rd_d, rd_s, rd_t, rd_a;
    logic              rf_we;
    logic [RIDX_W-1:0] rf_wa;
    logic [WORD_W-1:0] rf_wd;
    logic [WORD_W-1:0] alu_y;
    logic              br_take;

    assign f_op  = cur_q.ir[3:0];
    assign f_d   = cur_q.ir[5:4];
    assign f_s   = cur_q.ir[7:6];
    assign f_t   = cur_q.ir[9:8];
    assign imm_s = {{(WORD_W-8){cur_q.ir[15]}}, cur_q.ir[15:8]};
    assign imm_h = {cur_q.ir[15:8], 8'h00};
    assign rel12 = {{(WORD_W-12){cur_q.ir[15]}}, cur_q.ir[15:4]};

    nib16_regs u_regs (
        .clk  (clk),
        .rst  (rst),
        .ra_d (f_d),
        .ra_s (f_s),
        .ra_t (f_t),
        .rd_d (rd_d),
        .rd_s (rd_s),
        .rd_t (rd_t),
        .rd_a (rd_a),
        .we   (rf_we),
        .wa   (rf_wa),
        .wd   (rf_wd)
    );

    nib16_alu u_alu (
        .op    (cur_q.ir[11:8]),
        .shamt (cur_q.ir[15:13]),
        .x     (rd_d),
        .y     (rd_s),
        .res   (alu_y)
    );

    nib16_cmp u_cmp (
        .cond (cur_q.ir[12:10]),
        .x    (rd_d),
        .y    (rd_s),
        .take (br_take)
    );

    always_comb begin
        nxt_d     = cur_q;
        mem_addr  = MEM_AW'(cur_q.ip);
        mem_wdata = rd_d;
        mem_we    = 1'b0;
        stk_addr  = STK_AW'(cur_q.sp);
        stk_wdata = rd_s;
        stk_we    = 1'b0;
        rf_we     = 1'b0;
        rf_wa     = f_d;
        rf_wd     = rd_d;

        case (cur_q.st)
            S_FETCH: nxt_d.st = S_DECODE;

            S_DECODE: begin
                nxt_d.ir = mem_rdata;
                nxt_d.ip = cur_q.ip + 1'b1;
                nxt_d.st = S_EXEC;
            end

            S_EXEC: begin
                nxt_d.st = S_FETCH;
                case (f_op)
                    OP_MOVR: begin
                        rf_we = 1'b1;
                        rf_wd = rd_s + imm_s;
                    end
                    OP_IMM: begin
                        rf_we = 1'b1;
                        case (cur_q.ir[7:6])
                            2'd0:    rf_wd = {8'h00, cur_q.ir[15:8]};
                            2'd1:    rf_wd = imm_h;
                            2'd2:    rf_wd = rd_d + imm_s;
                            default: rf_wd = rd_d + imm_h;
                        endcase
                    end
                    OP_LDRB: begin
                        mem_addr  = MEM_AW'(rd_s + imm_s);
                        nxt_d.st  = S_LOAD;
                        nxt_d.sel = LD_MEM;
                        nxt_d.dst = f_d;
                    end
                    OP_STAB: begin
                        mem_addr = cur_q.ir[15:6];
                        mem_we   = 1'b1;
                    end
                    OP_ALU: begin
                        rf_we = 1'b1;
                        rf_wa = cur_q.ir[12] ? f_s : f_d;
                        rf_wd = alu_y;
                    end
                    OP_CALL: begin
                        stk_we    = 1'b1;
                        stk_wdata = cur_q.ip;
                        nxt_d.sp  = cur_q.sp + 1'b1;
                        nxt_d.ip  = rd_d;
                    end
                    OP_BCMP: begin
                        if (br_take) nxt_d.ip = rd_t;
                    end
                    OP_PUSH: begin
                        stk_we   = 1'b1;
                        nxt_d.sp = cur_q.sp + 1'b1;
                    end
                    OP_POP: begin
                        stk_addr  = STK_AW'(cur_q.sp - 1'b1);
                        nxt_d.sp  = cur_q.sp - 1'b1;
                        nxt_d.st  = S_LOAD;
                        nxt_d.sel = LD_STK;
                        nxt_d.dst = f_d;
                    end
                    OP_JREL: nxt_d.ip = cur_q.ip + rel12;
                    OP_JREG: nxt_d.ip = rd_s;
                    OP_LDAB: begin
                        mem_addr  = cur_q.ir[15:6];
                        nxt_d.st  = S_LOAD;
                        nxt_d.sel = LD_MEM;
                        nxt_d.dst = f_d;
                    end
                    OP_STRB: begin
                        mem_addr  = MEM_AW'(rd_d);
                        mem_wdata = rd_s;
                        mem_we    = 1'b1;
                    end
                    OP_MISC: begin
                        case (cur_q.ir[7:4])
                            SUB_SVC:  nxt_d.st = S_SVCREQ;
                            SUB_STOP: nxt_d.st = S_HALT;
                            SUB_RETN: begin
                                stk_addr  = STK_AW'(cur_q.sp - 1'b1);
                                nxt_d.sp  = cur_q.sp - 1'b1;
                                nxt_d.st  = S_LOAD;
                                nxt_d.sel = LD_IP;
                            end
                            default: ;
                        endcase
                    end
                    default: ;
                endcase
            end

            S_LOAD: begin
                nxt_d.st = S_FETCH;
                if (cur_q.sel == LD_IP) begin
                    nxt_d.ip = stk_rdata;
                end else begin
                    rf_we = 1'b1;
                    rf_wa = cur_q.dst;
                    rf_wd = (cur_q.sel == LD_STK) ? stk_rdata : mem_rdata;
                end
            end

            S_SVCREQ:  nxt_d.st = sys_ack ? S_FETCH : S_SVCWAIT;
            S_SVCWAIT: if (sys_ack) nxt_d.st = S_FETCH;
            S_HALT:    ;
            default:   nxt_d.st = S_FETCH;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cur_q.st  <= S_FETCH;
            cur_q.ip  <= '0;
            cur_q.sp  <= '0;
            cur_q.ir  <= '0;
            cur_q.sel <= LD_MEM;
            cur_q.dst <= '0;
        end else begin
            cur_q <= nxt_d;
        end
    end

    assign sys_req = (cur_q.st == S_SVCREQ);
    assign sys_arg = rd_a;
    assign halted  = (cur_q.st == S_HALT);

    AST_RESET_ORIGIN: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (cur_q.st == S_FETCH && cur_q.ip == '0 && cur_q.sp == '0)); // R1
    AST_PUSH_GROWS: assert property (@(posedge clk) disable iff (rst)
        stk_we |=> (cur_q.sp == $past(cur_q.sp) + 16'd1)); // R6
    AST_POP_SHRINKS: assert property (@(posedge clk) disable iff (rst)
        (cur_q.st == S_LOAD && cur_q.sel != LD_MEM) |-> (cur_q.sp == $past(cur_q.sp) - 16'd1)); // R7
    AST_SVC_PULSE: assert property (@(posedge clk) disable iff (rst)
        sys_req |=> !sys_req); // R10
    AST_SVC_FROZEN: assert property (@(posedge clk) disable iff (rst)
        (cur_q.st == S_SVCWAIT && !sys_ack) |=> (mem_addr == $past(mem_addr) && !mem_we && !stk_we)); // R10
    AST_HALT_STICKY: assert property (@(posedge clk) disable iff (rst)
        halted |=> (halted && !mem_we && !stk_we && $stable(mem_addr))); // R11

endmodule

// File: tb/tb_nib16_core.sv
`timescale 1ns/1ps
module tb_nib16_core;

    localparam int MEM_AW  = 10;
    localparam int STK_AW  = 8;
    localparam int ACK_DLY = 12;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic [MEM_AW-1:0] mem_addr;
    logic [15:0]       mem_wdata;
    logic              mem_we;
    logic [15:0]       mem_rdata;
    logic [STK_AW-1:0] stk_addr;
    logic [15:0]       stk_wdata;
    logic              stk_we;
    logic [15:0]       stk_rdata;
    logic              sys_req;
    logic [15:0]       sys_arg;
    logic              sys_ack;
    logic              halted;

    always #4 clk = ~clk;

    nib16_core #(.MEM_AW(MEM_AW), .STK_AW(STK_AW)) dut (
        .clk(clk), .rst(rst),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_we(mem_we), .mem_rdata(mem_rdata),
        .stk_addr(stk_addr), .stk_wdata(stk_wdata), .stk_we(stk_we), .stk_rdata(stk_rdata),
        .sys_req(sys_req), .sys_arg(sys_arg), .sys_ack(sys_ack), .halted(halted)
    );

    // Memory models
    logic [15:0] mem [0:(1<<MEM_AW)-1];
    logic [15:0] stk [0:(1<<STK_AW)-1];

    always @(posedge clk) begin
        if (mem_we) mem[mem_addr] <= mem_wdata;
        mem_rdata <= mem[mem_addr];
        if (stk_we) stk[stk_addr] <= stk_wdata;
        stk_rdata <= stk[stk_addr];
    end

    // Host model and monitors
    int          req_cnt;
    int          ack_cnt;
    int          halt_writes;
    logic        waiting;
    logic        moved;
    logic [15:0] arg_seen;
    logic [MEM_AW-1:0] hold_addr;

    always @(posedge clk) begin
        if (rst) begin
            req_cnt <= 0; ack_cnt <= 0; waiting <= 1'b0; moved <= 1'b0;
            sys_ack <= 1'b0; arg_seen <= '0; hold_addr <= '0; halt_writes <= 0;
        end else begin
            sys_ack <= 1'b0;
            if (halted && (mem_we || stk_we)) halt_writes <= halt_writes + 1;
            if (sys_req) begin
                req_cnt <= req_cnt + 1; arg_seen <= sys_arg;
                waiting <= 1'b1; ack_cnt <= 0; hold_addr <= mem_addr;
            end else if (waiting) begin
                if (mem_addr != hold_addr || mem_we || stk_we) moved <= 1'b1;
                if (ack_cnt == ACK_DLY) begin
                    sys_ack <= 1'b1; waiting <= 1'b0;
                end else begin
                    ack_cnt <= ack_cnt + 1;
                end
            end
        end
    end

    int n_chk = 0;
    int n_bad = 0;
    int pc;
    bit done = 1'b0;

    task automatic chk(input string tag, input logic [15:0] got, input logic [15:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s got %h exp %h", tag, got, exp);
        end
    endtask

    // Encoders
    function automatic logic [15:0] e_imm(logic [1:0] d, logic [1:0] m, logic [7:0] v);
        return {v, m, d, 4'd1};
    endfunction
    function automatic logic [15:0] e_movr(logic [1:0] d, logic [1:0] s, logic [7:0] v);
        return {v, s, d, 4'd0};
    endfunction
    function automatic logic [15:0] e_alu(logic [1:0] d, logic [1:0] s, logic [3:0] op, logic md, logic [2:0] sh);
        return {sh, md, op, s, d, 4'd4};
    endfunction
    function automatic logic [15:0] e_sta(logic [1:0] d, logic [9:0] a);
        return {a, d, 4'd3};
    endfunction
    function automatic logic [15:0] e_lda(logic [1:0] d, logic [9:0] a);
        return {a, d, 4'd11};
    endfunction
    function automatic logic [15:0] e_ldr(logic [1:0] d, logic [1:0] s, logic [7:0] off);
        return {off, s, d, 4'd2};
    endfunction
    function automatic logic [15:0] e_str(logic [1:0] d, logic [1:0] s);
        return {8'h00, s, d, 4'd12};
    endfunction
    function automatic logic [15:0] e_call(logic [1:0] d);
        return {10'h000, d, 4'd5};
    endfunction
    function automatic logic [15:0] e_bcmp(logic [1:0] d, logic [1:0] s, logic [1:0] t, logic [2:0] c);
        return {3'b000, c, t, s, d, 4'd6};
    endfunction
    function automatic logic [15:0] e_push(logic [1:0] s);
        return {8'h00, s, 2'b00, 4'd7};
    endfunction
    function automatic logic [15:0] e_pop(logic [1:0] d);
        return {10'h000, d, 4'd8};
    endfunction
    function automatic logic [15:0] e_jrel(logic [11:0] off);
        return {off, 4'd9};
    endfunction
    function automatic logic [15:0] e_jreg(logic [1:0] s);
        return {8'h00, s, 2'b00, 4'd10};
    endfunction
    function automatic logic [15:0] e_misc(logic [3:0] sub);
        return {8'h00, sub, 4'd13};
    endfunction

    localparam logic [15:0] W_HALT = 16'h001D;

    task automatic emit(input logic [15:0] w);
        mem[pc] = w;
        pc++;
    endtask

    task automatic ld16(input logic [1:0] d, input logic [15:0] v);
        emit(e_imm(d, 2'd0, v[7:0]));
        emit(e_imm(d, 2'd3, v[15:8]));
    endtask

    task automatic clear_all();
        rst = 1'b1;
        for (int i = 0; i < (1 << MEM_AW); i++) mem[i] = 16'h0000;
        for (int i = 0; i < (1 << STK_AW); i++) stk[i] = 16'hDEAD;
        for (int i = 0; i < 4; i++) mem[10'h3F0 + i] = 16'hAAAA;
        pc = 0;
    endtask

    task automatic run_prog(input string tag);
        int cyc;
        rst = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        cyc = 0;
        while (!halted && cyc < 3000) begin
            @(negedge clk);
            cyc++;
        end
        if (!halted) begin
            n_chk++; n_bad++;
            $display("FAIL %s no halt got %0d exp <3000", tag, cyc);
        end
    endtask

    typedef struct packed {
        logic        k;
        logic [3:0]  op;
        logic        md;
        logic [2:0]  sh;
        logic [15:0] a;
        logic [15:0] b;
        logic [15:0] e0;
        logic [15:0] e1;
    } vec_t;

    // k=0: ALU op on D=R0,S=R1; k=1: compare-and-jump with condition op
    localparam vec_t VECS [22] = '{
        '{1'b0, 4'd0,  1'b0, 3'd0, 16'h1234, 16'h1111, 16'h2345, 16'h1111},
        '{1'b0, 4'd1,  1'b0, 3'd0, 16'h0005, 16'h0007, 16'hFFFE, 16'h0007},
        '{1'b0, 4'd2,  1'b0, 3'd0, 16'h0123, 16'h0010, 16'h1230, 16'h0010},
        '{1'b0, 4'd3,  1'b0, 3'd0, 16'h0064, 16'h0007, 16'h000E, 16'h0007},
        '{1'b0, 4'd3,  1'b0, 3'd0, 16'h1234, 16'h0000, 16'hFFFF, 16'h0000},
        '{1'b0, 4'd4,  1'b0, 3'd0, 16'hFFFF, 16'h0003, 16'h0000, 16'h0003},
        '{1'b0, 4'd5,  1'b0, 3'd0, 16'h0000, 16'h0003, 16'hFFFF, 16'h0003},
        '{1'b0, 4'd6,  1'b0, 3'd3, 16'h1234, 16'h0000, 16'h91A0, 16'h0000},
        '{1'b0, 4'd7,  1'b0, 3'd7, 16'h8000, 16'h0000, 16'h0100, 16'h0000},
        '{1'b0, 4'd8,  1'b0, 3'd0, 16'hF0F0, 16'h3C3C, 16'h3030, 16'h3C3C},
        '{1'b0, 4'd9,  1'b0, 3'd0, 16'hF0F0, 16'h0F01, 16'hFFF1, 16'h0F01},
        '{1'b0, 4'd10, 1'b0, 3'd0, 16'hFFFF, 16'h1234, 16'hEDCB, 16'h1234},
        '{1'b0, 4'd11, 1'b0, 3'd0, 16'h00FF, 16'h0001, 16'hFF00, 16'h0001},
        '{1'b0, 4'd1,  1'b1, 3'd0, 16'h0009, 16'h0004, 16'h0009, 16'h0005},
        '{1'b1, 4'd0,  1'b0, 3'd0, 16'h0005, 16'h0005, 16'h0022, 16'h0000},
        '{1'b1, 4'd1,  1'b0, 3'd0, 16'h0005, 16'h0005, 16'h0011, 16'h0000},
        '{1'b1, 4'd2,  1'b0, 3'd0, 16'h0001, 16'h8000, 16'h0022, 16'h0000},
        '{1'b1, 4'd3,  1'b0, 3'd0, 16'h8000, 16'h0001, 16'h0022, 16'h0000},
        '{1'b1, 4'd4,  1'b0, 3'd0, 16'h0007, 16'h0007, 16'h0022, 16'h0000},
        '{1'b1, 4'd5,  1'b0, 3'd0, 16'h0003, 16'h0004, 16'h0011, 16'h0000},
        '{1'b1, 4'd6,  1'b0, 3'd0, 16'h0000, 16'h0009, 16'h0022, 16'h0000},
        '{1'b1, 4'd7,  1'b0, 3'd0, 16'h0000, 16'h0009, 16'h0011, 16'h0000}
    };

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    endtask

    initial begin
        #(8 * 190000);
        n_chk++; n_bad++;
        $display("FAIL watchdog got timeout exp completion");
        finish_run();
    end

    initial begin
        logic [15:0] ret_at;
        clear_all();

        // R1 reset outputs
        repeat (2) @(negedge clk);
        chk("R1 we during reset", {14'd0, mem_we, stk_we}, 16'h0000);
        chk("R1 req/halt during reset", {14'd0, sys_req, halted}, 16'h0000);

        // Vector table: ALU (R4) and compare-and-jump (R9)
        for (int v = 0; v < 22; v++) begin
            clear_all();
            ld16(2'd0, VECS[v].a);
            ld16(2'd1, VECS[v].b);
            if (!VECS[v].k) begin
                emit(e_alu(2'd0, 2'd1, VECS[v].op, VECS[v].md, VECS[v].sh));
                emit(e_sta(2'd0, 10'h3F0));
                emit(e_sta(2'd1, 10'h3F1));
                emit(W_HALT);
            end else begin
                emit(e_imm(2'd2, 2'd0, 8'd20));
                emit(e_bcmp(2'd0, 2'd1, 2'd2, VECS[v].op[2:0]));
                emit(e_imm(2'd3, 2'd0, 8'h11));
                emit(e_sta(2'd3, 10'h3F0));
                emit(W_HALT);
                pc = 20;
                emit(e_imm(2'd3, 2'd0, 8'h22));
                emit(e_sta(2'd3, 10'h3F0));
                emit(W_HALT);
            end
            if (v == 0) begin
                rst = 1'b1;
                repeat (3) @(posedge clk);
                @(negedge clk);
                rst = 1'b0;
                chk("R1 first fetch address", 16'(mem_addr), 16'h0000);
            end
            run_prog("vector");
            if (!VECS[v].k) begin
                chk($sformatf("R4 vec %0d D", v), mem[10'h3F0], VECS[v].e0);
                chk($sformatf("R4 vec %0d S", v), mem[10'h3F1], VECS[v].e1);
            end else begin
                chk($sformatf("R9 vec %0d", v), mem[10'h3F0], VECS[v].e0);
            end
        end

        // R2 R3 R12: moves, immediates, no-op codes
        clear_all();
        ld16(2'd0, 16'h0100);
        emit(e_movr(2'd1, 2'd0, 8'hFF));
        emit(e_imm(2'd2, 2'd0, 8'h05));
        emit(e_imm(2'd2, 2'd2, 8'hFD));
        emit(e_imm(2'd3, 2'd1, 8'hAB));
        emit(16'h00FE);
        emit(16'h00FF);
        emit(e_misc(4'd5));
        emit(e_sta(2'd1, 10'h3F0));
        emit(e_sta(2'd2, 10'h3F1));
        emit(e_sta(2'd3, 10'h3F2));
        emit(e_sta(2'd0, 10'h3F3));
        emit(W_HALT);
        run_prog("moves");
        chk("R2 register move sign-extended", mem[10'h3F0], 16'h00FF);
        chk("R3 set then signed add", mem[10'h3F1], 16'h0002);
        chk("R3 R12 high set, no-op opcodes", mem[10'h3F2], 16'hAB00);
        chk("R12 unused subcode", mem[10'h3F3], 16'h0100);

        // R5 loads and stores
        clear_all();
        mem[10'h200] = 16'h1234;
        mem[10'h201] = 16'hBEEF;
        mem[10'h1FD] = 16'h0F0F;
        ld16(2'd0, 16'h01FE);
        emit(e_ldr(2'd1, 2'd0, 8'h02));
        ld16(2'd2, 16'h0300);
        emit(e_str(2'd2, 2'd1));
        emit(e_lda(2'd3, 10'h201));
        emit(e_sta(2'd3, 10'h3F0));
        emit(e_ldr(2'd1, 2'd0, 8'hFF));
        emit(e_sta(2'd1, 10'h3F1));
        emit(W_HALT);
        run_prog("loads");
        chk("R5 register store of based load", mem[10'h300], 16'h1234);
        chk("R5 direct load", mem[10'h3F0], 16'hBEEF);
        chk("R5 negative offset load", mem[10'h3F1], 16'h0F0F);

        // R6 R7 stack, call, return
        clear_all();
        ld16(2'd0, 16'h1111);
        ld16(2'd1, 16'h2222);
        emit(e_push(2'd0));
        emit(e_push(2'd1));
        emit(e_pop(2'd2));
        emit(e_pop(2'd3));
        emit(e_sta(2'd2, 10'h3F0));
        emit(e_sta(2'd3, 10'h3F1));
        emit(e_imm(2'd0, 2'd0, 8'd40));
        emit(e_call(2'd0));
        ret_at = 16'(pc);
        emit(e_sta(2'd1, 10'h3F2));
        emit(W_HALT);
        pc = 40;
        emit(e_imm(2'd1, 2'd0, 8'h77));
        emit(e_misc(4'd2));
        run_prog("stack");
        chk("R6 pop order first", mem[10'h3F0], 16'h2222);
        chk("R6 pop order second", mem[10'h3F1], 16'h1111);
        chk("R6 slot above pointer", stk[1], 16'h2222);
        chk("R7 pushed return address", stk[0], ret_at);
        chk("R7 execution resumes after call", mem[10'h3F2], 16'h0077);

        // R8 relative jumps forward and backward
        clear_all();
        emit(e_imm(2'd3, 2'd0, 8'h01));
        emit(e_jrel(12'h001));
        emit(e_imm(2'd3, 2'd0, 8'h99));
        emit(e_jrel(12'h002));
        emit(e_sta(2'd3, 10'h3F0));
        emit(W_HALT);
        emit(e_imm(2'd3, 2'd2, 8'h04));
        emit(e_jrel(12'hFFC));
        run_prog("jrel");
        chk("R8 relative jumps", mem[10'h3F0], 16'h0005);

        // R8 register jump
        clear_all();
        emit(e_imm(2'd1, 2'd0, 8'd8));
        emit(e_jreg(2'd1));
        emit(e_imm(2'd3, 2'd0, 8'h99));
        emit(e_sta(2'd3, 10'h3F0));
        emit(W_HALT);
        pc = 8;
        emit(e_imm(2'd3, 2'd0, 8'h42));
        emit(e_jrel(12'hFF9));
        run_prog("jreg");
        chk("R8 register jump", mem[10'h3F0], 16'h0042);

        // R10 service request, R11 halt
        clear_all();
        ld16(2'd0, 16'h5A3C);
        emit(e_imm(2'd1, 2'd0, 8'h66));
        emit(e_misc(4'd0));
        emit(e_sta(2'd1, 10'h3F0));
        emit(W_HALT);
        run_prog("service");
        chk("R10 request count", 16'(req_cnt), 16'd1);
        chk("R10 argument is A", arg_seen, 16'h5A3C);
        chk("R10 frozen while waiting", {15'd0, moved}, 16'h0000);
        chk("R10 resumes after ack", mem[10'h3F0], 16'h0066);
        begin
            logic [MEM_AW-1:0] a0;
            a0 = mem_addr;
            repeat (20) @(negedge clk);
            chk("R11 halted sticky", {15'd0, halted}, 16'h0001);
            chk("R11 no writes after halt", 16'(halt_writes), 16'h0000);
            chk("R11 address held", 16'(mem_addr), 16'(a0));
        end

        // R1 registers and stack pointer cleared by reset
        clear_all();
        emit(e_sta(2'd0, 10'h3F0));
        emit(e_sta(2'd1, 10'h3F1));
        emit(e_sta(2'd2, 10'h3F2));
        emit(e_sta(2'd3, 10'h3F3));
        emit(e_push(2'd0));
        emit(W_HALT);
        run_prog("reset");
        for (int i = 0; i < 4; i++) chk($sformatf("R1 register %0d cleared", i), mem[10'h3F0 + i], 16'h0000);
        chk("R1 stack pointer cleared", stk[0], 16'h0000);

        finish_run();
    end

endmodule